// File: doc/BRIEF.md
# Doorbell-Driven Instruction Fetch Sequencer

This block turns doorbell writes into a stream of instruction fetch requests. Software adds 64-bit words to a pending counter through a doorbell write, and the sequencer fetches one 64-byte instruction at a time for every eight pending words. Instructions sit in a chain of command-buffer segments in memory. Each segment holds a whole number of instructions followed by one extra 64-bit word that holds the address of the next segment. When a segment has been used up, the sequencer reads that trailing word, reloads its address register from it, and carries on fetching from the new segment.

Control and status pins (enable, segment size, doorbell write, start-address write, the two read-back values and the overflow pulse) are plain signals. The memory request side is a valid/ready channel: once `mreq_valid` is high, `mreq_addr` and `mreq_next` stay fixed until the cycle in which `mreq_ready` is also high, and that cycle is the transfer. The response side has no ready: the memory returns exactly one `mrsp_valid` pulse per accepted request, and the block always takes it. The block keeps at most one request in flight, so the memory never sees a new request before the previous response.

The start-address register and the segment size must be changed only while the queue is disabled and no request is in flight. A segment size of 8n+1 words with n of at least 1 is required.

Top module: `dbell_fetch_seq`

## Requirements
- R1: After reset the pending count reads 0 and no request is presented; a doorbell write adds `db_wr_cnt` to the pending count, which `db_count` shows in the cycle after the write, and the count holds when there is neither a write nor a fetch.
- R2: When a doorbell write takes the pending count above 2^CNT_W-1, `dbell_ovf` is high for one cycle after the write and the count keeps the low CNT_W bits of the sum; reaching exactly 2^CNT_W-1 raises no overflow.
- R3: A request is launched only while `q_enable` is high and the pending count is at least 8; each accepted instruction fetch lowers the count by 8, and with the queue disabled or fewer than 8 words pending nothing is fetched.
- R4: A doorbell write in the same cycle as an accepted instruction fetch is applied as one net update (count + write - 8).
- R5: An instruction fetch has `mreq_next` = 0 and byte address `sa_ptr`*64; successive fetches in a segment are 64 bytes apart, and `sa_ptr` always reads the next fetch position in 64-byte units.
- R6: With a segment size of S = 8n+1 words, after n instruction fetches from a segment the next request (issued only once at least 8 words are pending) is a pointer read with `mreq_next` = 1 at the byte address just after the last instruction; it does not change the pending count.
- R7: The response to a pointer read loads bits 48:6 of `mrsp_data` into the address register; bits 5:0 and bits above 48 are ignored, and fetching resumes at the start of the new segment.
- R8: At most one request is outstanding: after a request is accepted, no new request is presented until its response has arrived.
- R9: While `mreq_valid` is high and `mreq_ready` is low, `mreq_valid`, `mreq_addr` and `mreq_next` hold their values.
- R10: A start-address write loads `sa_ptr` in the next cycle and restarts the segment position, so the following n fetches are instructions before any pointer read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_enable | input | 1 | Queue enable; gates the launch of new requests |
| seg_words | input | SEG_W | Segment size in 64-bit words, 8n+1 |
| db_wr_en | input | 1 | Doorbell write strobe |
| db_wr_cnt | input | CNT_W | Words to add to the pending count |
| db_count | output | CNT_W | Current pending word count |
| dbell_ovf | output | 1 | One-cycle pulse on pending-count overflow |
| sa_wr_en | input | 1 | Start-address write strobe |
| sa_wr_ptr | input | VA_W-6 | Start address bits 48:6 |
| sa_ptr | output | VA_W-6 | Next fetch address bits 48:6 |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request ready |
| mreq_addr | output | VA_W | Request byte address, 64-byte aligned |
| mreq_next | output | 1 | 0 = 64-byte instruction fetch, 1 = 8-byte next-segment pointer read |
| mrsp_valid | input | 1 | Response for the outstanding request |
| mrsp_data | input | DATA_W | Response data; used only for pointer reads |

## Verification
The bench builds the block with a 10-bit pending counter, so the wrap at 1023 and the exact boundary below it are reached with three doorbell writes instead of a million words. The segment size is an input, and the bench drives 9 and 17 words (one and two instructions per segment), so segment chaining happens several times within a handful of fetches. Memory back-pressure alternates ready every cycle, and the response delay is stretched, to exercise the hold rule and the single-outstanding rule while the expected address sequence is rebuilt from the start address and the returned pointers.

// File: rtl/dbfs_pkg.sv
package dbfs_pkg;
  typedef enum logic {
    REQ_INST = 1'b0,
    REQ_NEXT = 1'b1
  } req_kind_e;

  localparam int unsigned INST_WORDS = 8;
  localparam int unsigned LINE_LSB   = 6;
endpackage

// File: rtl/dbfs_dbell_cnt.sv
module dbfs_dbell_cnt
  import dbfs_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W:0] DEC_AMT = (CNT_W+1)'(INST_WORDS);

  logic [CNT_W:0] add_amt;
  logic [CNT_W:0] sum;

  // Single net update: add and decrement combine into one result
  assign add_amt = wr_en ? {1'b0, wr_cnt} : '0;
  assign sum     = {1'b0, cnt} + add_amt - (dec ? DEC_AMT : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      cnt <= sum[CNT_W-1:0];
      ovf <= sum[CNT_W];
    end
  end

  AST_DEC_NEEDS_INST: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt >= CNT_W'(INST_WORDS))); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !dec) |=> $stable(cnt)); // R1
  AST_OVF_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> $past(wr_en)); // R2
endmodule

// File: rtl/dbfs_seg_track.sv
module dbfs_seg_track
  import dbfs_pkg::*;
#(
  parameter int unsigned VA_W   = 49,
  parameter int unsigned SEG_W  = 13,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned PTR_W = VA_W - LINE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEG_W-1:0]  seg_words,
  input  logic              ld_en,
  input  logic [PTR_W-1:0]  ld_ptr,
  input  logic              inst_adv,
  input  logic              next_load,
  input  logic [DATA_W-1:0] next_data,
  output logic [PTR_W-1:0]  ptr,
  output logic              exhausted
);
  localparam int unsigned INST_SH = $clog2(INST_WORDS);

  logic [SEG_W-1:0] idx_q;
  logic [SEG_W-1:0] n_inst;
  logic             unused_bits;

  assign n_inst      = seg_words >> INST_SH;
  assign exhausted   = (idx_q >= n_inst);
  assign unused_bits = ^{next_data[LINE_LSB-1:0], next_data[DATA_W-1:VA_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      idx_q <= '0;
    end else if (ld_en) begin
      ptr   <= ld_ptr;
      idx_q <= '0;
    end else if (next_load) begin
      ptr   <= next_data[VA_W-1:LINE_LSB];
      idx_q <= '0;
    end else if (inst_adv) begin
      ptr   <= ptr + 1'b1;
      idx_q <= idx_q + 1'b1;
    end
  end

  AST_NO_INST_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    inst_adv |-> !exhausted); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_adv && !ld_en && !next_load) |=> (ptr == $past(ptr) + 1'b1)); // R5
endmodule

// File: rtl/dbfs_fetch_ctl.sv
module dbfs_fetch_ctl
  import dbfs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      q_enable,
  input  logic      cnt_ok,
  input  logic      exhausted,
  input  logic      mreq_ready,
  input  logic      mrsp_valid,
  output logic      mreq_valid,
  output req_kind_e mreq_kind,
  output logic      inst_acc,
  output logic      next_rsp
);
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } st_e;

  st_e       st_q;
  req_kind_e kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      kind_q <= REQ_INST;
    end else begin
      case (st_q)
        ST_IDLE: if (q_enable && cnt_ok) begin
          st_q   <= ST_ISSUE;
          kind_q <= exhausted ? REQ_NEXT : REQ_INST;
        end
        ST_ISSUE: if (mreq_ready) st_q <= ST_WAIT;
        ST_WAIT:  if (mrsp_valid) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign mreq_valid = (st_q == ST_ISSUE);
  assign mreq_kind  = kind_q;
  assign inst_acc   = mreq_valid && mreq_ready && (kind_q == REQ_INST);
  assign next_rsp   = (st_q == ST_WAIT) && mrsp_valid && (kind_q == REQ_NEXT);

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_ready) |=> !mreq_valid); // R8
  AST_LAUNCH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mreq_valid) |-> ($past(q_enable) && $past(cnt_ok))); // R3
endmodule

// File: rtl/dbell_fetch_seq.sv
module dbell_fetch_seq
  import dbfs_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned VA_W   = 49,
  parameter int unsigned SEG_W  = 13,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned PTR_W = VA_W - LINE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_enable,
  input  logic [SEG_W-1:0]  seg_words,
  input  logic              db_wr_en,
  input  logic [CNT_W-1:0]  db_wr_cnt,
  output logic [CNT_W-1:0]  db_count,
  output logic              dbell_ovf,
  input  logic              sa_wr_en,
  input  logic [PTR_W-1:0]  sa_wr_ptr,
  output logic [PTR_W-1:0]  sa_ptr,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic [VA_W-1:0]   mreq_addr,
  output logic              mreq_next,
  input  logic              mrsp_valid,
  input  logic [DATA_W-1:0] mrsp_data
);
  logic      cnt_ok;
  logic      exhausted;
  logic      inst_acc;
  logic      next_rsp;
  req_kind_e kind;

  assign cnt_ok    = (db_count >= CNT_W'(INST_WORDS));
  assign mreq_addr = {sa_ptr, {LINE_LSB{1'b0}}};
  assign mreq_next = (kind == REQ_NEXT);

  dbfs_dbell_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (db_wr_en),
    .wr_cnt (db_wr_cnt),
    .dec    (inst_acc),
    .cnt    (db_count),
    .ovf    (dbell_ovf)
  );

  dbfs_seg_track #(.VA_W(VA_W), .SEG_W(SEG_W), .DATA_W(DATA_W)) u_seg (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_words (seg_words),
    .ld_en     (sa_wr_en),
    .ld_ptr    (sa_wr_ptr),
    .inst_adv  (inst_acc),
    .next_load (next_rsp),
    .next_data (mrsp_data),
    .ptr       (sa_ptr),
    .exhausted (exhausted)
  );

  dbfs_fetch_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_enable   (q_enable),
    .cnt_ok     (cnt_ok),
    .exhausted  (exhausted),
    .mreq_ready (mreq_ready),
    .mrsp_valid (mrsp_valid),
    .mreq_valid (mreq_valid),
    .mreq_kind  (kind),
    .inst_acc   (inst_acc),
    .next_rsp   (next_rsp)
  );

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=>
      (mreq_valid && $stable(mreq_addr) && $stable(mreq_next))); // R9
  AST_NEXT_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_ready && mreq_next && !db_wr_en) |=> $stable(db_count)); // R6
endmodule

// File: tb/test_dbell_fetch_seq.sv
module test_dbell_fetch_seq;
  localparam int CNT_W  = 10;
  localparam int VA_W   = 49;
  localparam int SEG_W  = 13;
  localparam int DATA_W = 64;
  localparam int PTR_W  = VA_W - 6;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              q_enable;
  logic [SEG_W-1:0]  seg_words;
  logic              db_wr_en;
  logic [CNT_W-1:0]  db_wr_cnt;
  logic [CNT_W-1:0]  db_count;
  logic              dbell_ovf;
  logic              sa_wr_en;
  logic [PTR_W-1:0]  sa_wr_ptr;
  logic [PTR_W-1:0]  sa_ptr;
  logic              mreq_valid;
  logic              mreq_ready;
  logic [VA_W-1:0]   mreq_addr;
  logic              mreq_next;
  logic              mrsp_valid;
  logic [DATA_W-1:0] mrsp_data;

  int n_run  = 0;
  int n_fail = 0;

  logic [VA_W-1:0] log_addr [64];
  logic            log_kind [64];
  int              log_n = 0;
  int              rdy_mode = 0;
  logic            man_rdy = 1'b0;
  logic            bp_tog = 1'b0;
  int              rsp_dly = 0;
  int              viol = 0;

  always #5 clk = ~clk;

  assign mreq_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? bp_tog : man_rdy;

  dbell_fetch_seq #(.CNT_W(CNT_W), .VA_W(VA_W), .SEG_W(SEG_W), .DATA_W(DATA_W)) i_dbell_fetch_seq (
    .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .seg_words(seg_words),
    .db_wr_en(db_wr_en), .db_wr_cnt(db_wr_cnt), .db_count(db_count), .dbell_ovf(dbell_ovf),
    .sa_wr_en(sa_wr_en), .sa_wr_ptr(sa_wr_ptr), .sa_ptr(sa_ptr),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_addr(mreq_addr),
    .mreq_next(mreq_next), .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data)
  );

  // Pointer word stored at a segment's end: next segment 64 KiB further on,
  // with junk in bits 5:0 and above bit 48 (R7)
  function automatic logic [63:0] ptr_word(input logic [VA_W-1:0] a);
    logic [VA_W-1:0] t;
    t = a + 49'h10000;
    return {15'h5a5a, t[VA_W-1:6], 6'h2d};
  endfunction

  function automatic logic [PTR_W-1:0] next_ptr(input logic [VA_W-1:0] a);
    logic [VA_W-1:0] t;
    t = a + 49'h10000;
    return t[VA_W-1:6];
  endfunction

  // Memory model: drives responses at negedge, records transfers just before posedge
  initial begin
    logic        pend;
    int          dcnt;
    logic [63:0] pdata;
    pend = 1'b0;
    dcnt = 0;
    pdata = '0;
    mrsp_valid = 1'b0;
    mrsp_data = '0;
    forever begin
      @(negedge clk);
      mrsp_valid = 1'b0;
      if (pend) begin
        if (dcnt == 0) begin
          mrsp_valid = 1'b1;
          mrsp_data = pdata;
          pend = 1'b0;
        end else dcnt--;
      end
      bp_tog = ~bp_tog;
      #3;
      if (pend && mreq_valid) viol++;
      if (mreq_valid && mreq_ready) begin
        if (log_n < 64) begin
          log_addr[log_n] = mreq_addr;
          log_kind[log_n] = mreq_next;
        end
        log_n++;
        pend = 1'b1;
        dcnt = rsp_dly;
        pdata = mreq_next ? ptr_word(mreq_addr) : 64'h0;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic db_write(input int v);
    @(negedge clk);
    db_wr_en = 1'b1;
    db_wr_cnt = CNT_W'(v);
    @(negedge clk);
    db_wr_en = 1'b0;
  endtask

  task automatic sa_write(input logic [PTR_W-1:0] p);
    @(negedge clk);
    sa_wr_en = 1'b1;
    sa_wr_ptr = p;
    @(negedge clk);
    sa_wr_en = 1'b0;
  endtask

  // Rebuild the expected request list from start pointer, n per segment, k instructions
  task automatic expect_seq(input logic [PTR_W-1:0] p, input int n, input int k);
    logic [PTR_W-1:0] ep;
    int idx;
    int e;
    ep = p;
    idx = 0;
    e = 0;
    for (int i = 0; i < k; i++) begin
      if (idx == n) begin
        chk("R6", "pointer read kind", 64'(log_kind[e]), 64'd1);
        chk("R6", "pointer read addr", 64'(log_addr[e]), 64'({ep, 6'b0}));
        ep = next_ptr({ep, 6'b0});
        idx = 0;
        e++;
      end
      chk("R5", "fetch kind", 64'(log_kind[e]), 64'd0);
      chk("R7", "fetch addr", 64'(log_addr[e]), 64'({ep, 6'b0}));
      ep = ep + 1'b1;
      idx++;
      e++;
    end
    chk("R8", "request count", 64'(log_n), 64'(e));
    chk("R5", "next fetch pointer", 64'(sa_ptr), 64'(ep));
    chk("R3", "count drained", 64'(db_count), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1", "count after reset", 64'(db_count), 64'd0);
    chk("R2", "ovf after reset", 64'(dbell_ovf), 64'd0);
    chk("R1", "no request after reset", 64'(mreq_valid), 64'd0);
    chk("R10", "pointer after reset", 64'(sa_ptr), 64'd0);
  endtask

  task automatic t_disabled;
    seg_words = 13'd9;
    sa_write(43'h100);
    chk("R10", "start address readback", 64'(sa_ptr), 64'h100);
    log_n = 0;
    db_write(24);
    chk("R1", "count after write", 64'(db_count), 64'd24);
    wait_cyc(20);
    chk("R3", "no fetch while disabled", 64'(log_n), 64'd0);
    chk("R3", "count kept while disabled", 64'(db_count), 64'd24);
    q_enable = 1'b1;
    wait_cyc(80);
    expect_seq(43'h100, 1, 3);
    q_enable = 1'b0;
  endtask

  task automatic t_partial;
    seg_words = 13'd17;
    sa_write(43'h2000);
    log_n = 0;
    q_enable = 1'b1;
    db_write(4);
    wait_cyc(15);
    chk("R3", "no fetch below 8 words", 64'(log_n), 64'd0);
    chk("R3", "partial count kept", 64'(db_count), 64'd4);
    db_write(4);
    wait_cyc(20);
    expect_seq(43'h2000, 2, 1);
    q_enable = 1'b0;
  endtask

  task automatic t_ovf;
    db_write(1016);
    chk("R2", "no ovf below max", 64'(dbell_ovf), 64'd0);
    db_write(7);
    chk("R2", "count at max", 64'(db_count), 64'd1023);
    chk("R2", "no ovf at max", 64'(dbell_ovf), 64'd0);
    @(negedge clk);
    db_wr_en = 1'b1;
    db_wr_cnt = CNT_W'(9);
    @(negedge clk);
    db_wr_en = 1'b0;
    chk("R2", "ovf pulse", 64'(dbell_ovf), 64'd1);
    chk("R2", "wrapped count", 64'(db_count), 64'd8);
    @(negedge clk);
    chk("R2", "ovf one cycle", 64'(dbell_ovf), 64'd0);
    seg_words = 13'd17;
    sa_write(43'h3000);
    log_n = 0;
    q_enable = 1'b1;
    wait_cyc(20);
    expect_seq(43'h3000, 2, 1);
    q_enable = 1'b0;
  endtask

  task automatic t_net;
    int guard;
    seg_words = 13'd17;
    sa_write(43'h4000);
    log_n = 0;
    rdy_mode = 2;
    man_rdy = 1'b0;
    db_write(8);
    q_enable = 1'b1;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!mreq_valid && guard < 20);
    man_rdy = 1'b1;
    db_wr_en = 1'b1;
    db_wr_cnt = CNT_W'(16);
    @(negedge clk);
    man_rdy = 1'b0;
    db_wr_en = 1'b0;
    chk("R4", "net update count", 64'(db_count), 64'd16);
    rdy_mode = 0;
    wait_cyc(40);
    expect_seq(43'h4000, 2, 3);
    q_enable = 1'b0;
  endtask

  task automatic t_backpressure;
    seg_words = 13'd17;
    sa_write(43'h7fff_fffe);
    log_n = 0;
    viol = 0;
    rdy_mode = 1;
    rsp_dly = 3;
    db_write(40);
    q_enable = 1'b1;
    wait_cyc(150);
    expect_seq(43'h7fff_fffe, 2, 5);
    chk("R8", "request while response pending", 64'(viol), 64'd0);
    q_enable = 1'b0;
    rdy_mode = 0;
    rsp_dly = 0;
  endtask

  task automatic t_reload;
    seg_words = 13'd17;
    sa_write(43'h5000);
    log_n = 0;
    q_enable = 1'b1;
    db_write(8);
    wait_cyc(20);
    expect_seq(43'h5000, 2, 1);
    q_enable = 1'b0;
    sa_write(43'h6000);
    chk("R10", "reloaded pointer", 64'(sa_ptr), 64'h6000);
    log_n = 0;
    db_write(16);
    q_enable = 1'b1;
    wait_cyc(30);
    expect_seq(43'h6000, 2, 2);
    q_enable = 1'b0;
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    q_enable = 1'b0;
    seg_words = 13'd17;
    db_wr_en = 1'b0;
    db_wr_cnt = '0;
    sa_wr_en = 1'b0;
    sa_wr_ptr = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_partial();
    t_ovf();
    t_net();
    t_backpressure();
    t_reload();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule